// File: doc/BRIEF.md
# NOR flash command interface

This block models the command decoder and internal write controller of a parallel NOR flash. A host drives single-cycle bus writes carrying an address and a data byte. The low byte of each write is decoded as a command or as the second cycle of a two-cycle sequence. Reads are combinational: `bus_rdata` follows `bus_addr` from whichever read source the current mode selects. The sources are the storage array, the status registers, the identifier space and the query space.

Program and erase run for a fixed number of clock cycles, set by parameters. During that time the status register reports busy. An erase can be suspended so that reads or a program can run. A program can be suspended for reads. Per-block lock bits, set and cleared by command, stop program and erase from touching a block. A small on-chip RAM stands in for the cell array. It starts as all ones after reset. A program can only clear bits (new word = old AND data). An erase sets a whole block to ones.

The bus is not a stream. Every write is taken in the cycle it is presented, so no back-pressure exists. The host learns that an operation has finished by polling the ready bit in the status register. With the default parameters there are 256 words of 8 bits in four blocks of 64 words. The block number is formed by the top two address bits.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, every array word reads FFh, all lock bits are clear, and the status register reads 80h.
- R2: A write of FFh selects array read, 70h selects status read, 90h selects identifier read and 98h selects query read. Program, erase, lock, suspend and resume commands switch reads to status.
- R3: The status register, read at an even address in status mode, has this layout. Bit 7 = ready (no operation executing). Bit 6 = erase suspended. Bit 5 = erase or lock-clear error. Bit 4 = program or sequence error. Bit 3 = program-voltage error. Bit 2 = program suspended. Bit 1 = locked-block error. Bit 0 = 0.
- R4: A 40h write followed by one write of address/data starts a program. Status bit 7 reads 0 for PROG_CYC cycles. Afterwards the word holds its old value ANDed with the data.
- R5: A 20h write to a block followed by D0h to the same block erases it: busy for ERASE_CYC cycles, then all words of the block read FFh. Any other second write sets bits 5 and 4, and nothing is erased.
- R6: B0h during a running program suspends it. Bit 2 = 1 and bit 7 = 1, the word stays unchanged, and the remaining time is frozen. D0h resumes it, and it completes after the remaining cycles.
- R7: B0h during a running erase suspends it (bit 6 = 1). A program may then run. D0h written while that program is busy is ignored. D0h after the program has finished resumes the erase.
- R8: 60h then 01h sets the lock bit of the addressed block. 60h then D0h clears all lock bits. If vpp_ok is low on the second write, bits 5 and 3 are set and the lock bits are unchanged.
- R9: A program or erase aimed at a locked block is not executed. It sets bit 1 together with bit 4 (program) or bit 5 (erase).
- R10: 50h clears status bits 5, 4, 3 and 1. Until then these bits stay set, and further errors accumulate in them.
- R11: While an operation executes, every write except B0h and 70h is ignored, and reads keep returning status.
- R12: In identifier mode, address offset (addr mod 4) 0 returns MFG_CODE and offset 1 returns DEV_CODE. Offset 2 returns the addressed block's lock bit in bit 0, and offset 3 returns 0. In query mode, addr mod 32 = 10h, 11h, 12h return 51h, 52h, 59h, 13h returns the block count, and every other offset returns 0.
- R13: In status mode an odd address returns the extended status. Its bit 7 is 1 when a new program could be accepted (not busy and no program suspended). All its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per bus write |
| bus_addr | input | AW | Word address for writes and reads |
| bus_wdata | input | DW | Write data; low byte is the command code |
| vpp_ok | input | 1 | Program voltage in range |
| bus_rdata | output | DW | Read data from the selected mode |

## Verification
A wrong internal state in this block always shows up on `bus_rdata`, but only in the read mode that exposes it. A timer that is off by one moves the edge of status bit 7 by one cycle. A lost suspend flag clears bit 2 or bit 6, and it also lets the frozen operation finish early, which shows up in the array word. A lock bit that is set wrongly shows in the identifier read at offset 2 and in the error bits of the next program. The bench keeps a behavioural model in step with every write. It compares the read data on every clock, so a divergence is reported on the first falling edge after the faulty rising edge, provided the current mode shows the corrupted state.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID, RD_QUERY} rd_mode_t;
  typedef enum logic [1:0] {SU_NONE, SU_PROG, SU_ERASE, SU_LOCK} setup_t;

  localparam logic [7:0] CMD_READ  = 8'hFF;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_LOCK  = 8'h60;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_CONF  = 8'hD0;
  localparam logic [7:0] CMD_LSET  = 8'h01;
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  assign done = en && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= '0;
    else if (en && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nor_lock_bits.sv
module nor_lock_bits #(
  parameter int BLK_BITS = 2,
  localparam int NBLK = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [BLK_BITS-1:0] set_idx,
  input  logic                clr_all,
  output logic [NBLK-1:0]     locks
);
  logic [NBLK-1:0] nxt;

  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    assign nxt[g] = clr_all ? 1'b0
                  : (set_en && set_idx == BLK_BITS'(g)) ? 1'b1 : locks[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) locks <= '0;
    else        locks <= nxt;
  end
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BLK_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  input  logic                prog_en,
  input  logic [AW-1:0]       prog_addr,
  input  logic [DW-1:0]       prog_data,
  input  logic                erase_en,
  input  logic [BLK_BITS-1:0] erase_blk
);
  localparam int DEPTH = 1 << AW;
  localparam int OW    = AW - BLK_BITS;
  localparam int WORDS = 1 << OW;

  logic [DW-1:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (erase_en)
        for (int j = 0; j < WORDS; j++) mem[{erase_blk, OW'(j)}] <= '1;
      if (prog_en) mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl import nor_pkg::*; #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int BLK_BITS = 2,
  parameter int PROG_CYC = 12,
  parameter int ERASE_CYC = 40,
  parameter logic [7:0] MFG_CODE = 8'hA5,
  parameter logic [7:0] DEV_CODE = 8'h3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          vpp_ok,
  output logic [DW-1:0] bus_rdata
);
  localparam int NBLK = 1 << BLK_BITS;

  rd_mode_t rmode;
  setup_t   setup;
  logic prun, psusp, erun, esusp;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pdata;
  logic [BLK_BITS-1:0] eblk;
  logic [3:0] err_q;               // {bit5, bit4, bit3, bit1}
  logic pdone, edone, busy;
  logic start_p, start_e, lk_set, lk_clr;
  logic [NBLK-1:0] locks;
  logic [DW-1:0] arr_q;
  logic [7:0] sr, xsr, cmd;
  logic [BLK_BITS-1:0] wblk;

  assign cmd  = bus_wdata[7:0];
  assign wblk = bus_addr[AW-1 -: BLK_BITS];
  assign busy = (prun && !psusp) || (erun && !esusp);
  assign sr   = {!busy, esusp, err_q[3], err_q[2], err_q[1], psusp, err_q[0], 1'b0};
  assign xsr  = {!busy && !psusp, 7'd0};

  always_comb begin
    start_p = bus_wr && setup == SU_PROG && !locks[wblk];
    start_e = bus_wr && setup == SU_ERASE && cmd == CMD_CONF && wblk == eblk && !locks[eblk];
    lk_set  = bus_wr && setup == SU_LOCK && cmd == CMD_LSET && vpp_ok;
    lk_clr  = bus_wr && setup == SU_LOCK && cmd == CMD_CONF && vpp_ok;
  end

  nor_busy_timer #(.CYC(PROG_CYC)) u_ptmr (
    .clk(clk), .rst_n(rst_n), .start(start_p), .en(prun && !psusp), .done(pdone));
  nor_busy_timer #(.CYC(ERASE_CYC)) u_etmr (
    .clk(clk), .rst_n(rst_n), .start(start_e), .en(erun && !esusp), .done(edone));

  nor_lock_bits #(.BLK_BITS(BLK_BITS)) u_lock (
    .clk(clk), .rst_n(rst_n), .set_en(lk_set), .set_idx(wblk),
    .clr_all(lk_clr), .locks(locks));

  nor_array #(.AW(AW), .DW(DW), .BLK_BITS(BLK_BITS)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(bus_addr), .rd_data(arr_q),
    .prog_en(pdone), .prog_addr(paddr), .prog_data(pdata),
    .erase_en(edone), .erase_blk(eblk));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmode <= RD_ARRAY;
      setup <= SU_NONE;
      {prun, psusp, erun, esusp} <= '0;
      paddr <= '0;
      pdata <= '0;
      eblk  <= '0;
      err_q <= '0;
    end else begin
      if (pdone) prun <= 1'b0;
      if (edone) erun <= 1'b0;
      if (bus_wr) begin
        if (setup != SU_NONE) begin
          setup <= SU_NONE;
          unique case (setup)
            SU_PROG:
              if (locks[wblk]) {err_q[2], err_q[0]} <= 2'b11;
              else begin
                prun  <= 1'b1;
                paddr <= bus_addr;
                pdata <= bus_wdata;
              end
            SU_ERASE:
              if (cmd != CMD_CONF || wblk != eblk) err_q[3:2] <= 2'b11;
              else if (locks[eblk]) {err_q[3], err_q[0]} <= 2'b11;
              else erun <= 1'b1;
            default:
              if (cmd == CMD_LSET || cmd == CMD_CONF) begin
                if (!vpp_ok) {err_q[3], err_q[1]} <= 2'b11;
              end else err_q[3:2] <= 2'b11;
          endcase
        end else if (busy) begin
          if (cmd == CMD_SUSP) begin
            rmode <= RD_STATUS;
            if (prun && !psusp && !pdone) psusp <= 1'b1;
            else if (erun && !esusp && !edone && !prun) esusp <= 1'b1;
          end else if (cmd == CMD_STAT) rmode <= RD_STATUS;
        end else begin
          case (cmd)
            CMD_READ:  rmode <= RD_ARRAY;
            CMD_STAT:  rmode <= RD_STATUS;
            CMD_IDENT: rmode <= RD_ID;
            CMD_QUERY: rmode <= RD_QUERY;
            CMD_CLR:   err_q <= '0;
            CMD_PROG:
              if (!psusp && !prun) begin
                setup <= SU_PROG;
                rmode <= RD_STATUS;
              end
            CMD_ERASE:
              if (!erun && !psusp) begin
                setup <= SU_ERASE;
                eblk  <= wblk;
                rmode <= RD_STATUS;
              end
            CMD_LOCK:
              if (!erun && !prun) begin
                setup <= SU_LOCK;
                rmode <= RD_STATUS;
              end
            CMD_CONF:
              if (psusp) begin
                psusp <= 1'b0;
                rmode <= RD_STATUS;
              end else if (esusp) begin
                esusp <= 1'b0;
                rmode <= RD_STATUS;
              end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (rmode)
      RD_ARRAY:  bus_rdata = arr_q;
      RD_STATUS: bus_rdata = DW'(bus_addr[0] ? xsr : sr);
      RD_ID:
        case (bus_addr[1:0])
          2'd0:    bus_rdata = DW'(MFG_CODE);
          2'd1:    bus_rdata = DW'(DEV_CODE);
          2'd2:    bus_rdata = DW'(locks[wblk]);
          default: bus_rdata = '0;
        endcase
      default:
        case (bus_addr[4:0])
          5'h10:   bus_rdata = DW'(8'h51);
          5'h11:   bus_rdata = DW'(8'h52);
          5'h12:   bus_rdata = DW'(8'h59);
          5'h13:   bus_rdata = DW'(NBLK);
          default: bus_rdata = '0;
        endcase
    endcase
  end
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk import nor_pkg::*; #(
  parameter int DW = 8,
  parameter int NBLK = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic            vpp_ok,
  input logic            busy,
  input logic            prun,
  input logic            psusp,
  input logic            pdone,
  input logic            esusp,
  input setup_t          setup,
  input rd_mode_t        rmode,
  input logic [NBLK-1:0] locks,
  input logic [3:0]      err_q
);
  // R6: a suspend written to a running program takes hold on the next cycle
  p_prog_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[7:0] == 8'hB0 && prun && !psusp && !pdone) |=> psusp);

  // R6: a suspended program never reaches completion
  p_frozen_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psusp |-> !pdone);

  // R7: erase stays suspended while a program is in flight
  p_erase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (esusp && prun) |=> esusp);

  // R8: lock bits never move while the program voltage is bad
  p_lock_vpp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> $stable(locks));

  // R10: the clear command empties every error bit
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[7:0] == 8'h50 && !busy && setup == SU_NONE) |=> (err_q == 4'd0));

  // R11: status reads persist while an operation executes
  p_busy_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rmode == RD_STATUS) |=> (rmode == RD_STATUS));
endmodule

bind nor_cmd_ctrl nor_cmd_chk #(.DW(DW), .NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .vpp_ok(vpp_ok), .busy(busy), .prun(prun), .psusp(psusp), .pdone(pdone),
  .esusp(esusp), .setup(setup), .rmode(rmode), .locks(locks), .err_q(err_q));

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;
  localparam int AW = 8, DW = 8, BB = 2, PC = 12, EC = 40;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, vpp_ok = 1'b1;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  int vectors = 0, fails = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  nor_cmd_ctrl #(.AW(AW), .DW(DW), .BLK_BITS(BB), .PROG_CYC(PC), .ERASE_CYC(EC),
                 .MFG_CODE(8'hA5), .DEV_CODE(8'h3C)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .vpp_ok(vpp_ok), .bus_rdata(bus_rdata));

  // behavioural reference model
  int m_mode, m_setup, m_prem, m_erem, m_paddr, m_eblk;
  bit [7:0] m_pdata;
  bit m_prun, m_psusp, m_erun, m_esusp, s5, s4, s3, s1;
  bit [7:0] m_mem [256];
  bit m_lock [4];

  function automatic int blk_of(int a); return (a >> 6) & 3; endfunction

  function automatic bit m_busy();
    return (m_prun && !m_psusp) || (m_erun && !m_esusp);
  endfunction

  task automatic model_reset();
    m_mode = 0; m_setup = 0; m_prun = 0; m_psusp = 0; m_erun = 0; m_esusp = 0;
    m_prem = 0; m_erem = 0; m_paddr = 0; m_pdata = 0; m_eblk = 0;
    {s5, s4, s3, s1} = 4'b0;
    foreach (m_mem[i]) m_mem[i] = 8'hFF;
    foreach (m_lock[i]) m_lock[i] = 1'b0;
  endtask

  task automatic model_step(bit wr, int a, bit [7:0] d, bit vp);
    bit busy0 = m_busy();
    bit prun0 = m_prun;
    bit pd = m_prun && !m_psusp && m_prem == 1;
    bit ed = m_erun && !m_esusp && m_erem == 1;
    int wb = blk_of(a);
    if (m_prun && !m_psusp) begin
      if (pd) begin m_mem[m_paddr] &= m_pdata; m_prun = 0; end
      else m_prem--;
    end
    if (m_erun && !m_esusp) begin
      if (ed) begin
        for (int i = 0; i < 64; i++) m_mem[m_eblk * 64 + i] = 8'hFF;
        m_erun = 0;
      end else m_erem--;
    end
    if (!wr) return;
    if (m_setup != 0) begin
      case (m_setup)
        1: if (m_lock[wb]) begin s4 = 1; s1 = 1; end
           else begin m_prun = 1; m_prem = PC; m_paddr = a; m_pdata = d; end
        2: if (d != 8'hD0 || wb != m_eblk) begin s5 = 1; s4 = 1; end
           else if (m_lock[m_eblk]) begin s5 = 1; s1 = 1; end
           else begin m_erun = 1; m_erem = EC; end
        default:
          if (d == 8'h01 || d == 8'hD0) begin
            if (!vp) begin s5 = 1; s3 = 1; end
            else if (d == 8'h01) m_lock[wb] = 1;
            else foreach (m_lock[i]) m_lock[i] = 0;
          end else begin s5 = 1; s4 = 1; end
      endcase
      m_setup = 0;
    end else if (busy0) begin
      if (d == 8'hB0) begin
        m_mode = 1;
        if (prun0 && !m_psusp && !pd) m_psusp = 1;
        else if (m_erun && !m_esusp && !ed && !prun0) m_esusp = 1;
      end else if (d == 8'h70) m_mode = 1;
    end else begin
      case (d)
        8'hFF: m_mode = 0;
        8'h70: m_mode = 1;
        8'h90: m_mode = 2;
        8'h98: m_mode = 3;
        8'h50: {s5, s4, s3, s1} = 4'b0;
        8'h40: if (!m_psusp) begin m_setup = 1; m_mode = 1; end
        8'h20: if (!m_erun && !m_psusp) begin m_setup = 2; m_eblk = wb; m_mode = 1; end
        8'h60: if (!m_erun && !m_prun) begin m_setup = 3; m_mode = 1; end
        8'hD0: if (m_psusp) begin m_psusp = 0; m_mode = 1; end
               else if (m_esusp) begin m_esusp = 0; m_mode = 1; end
        default: ;
      endcase
    end
  endtask

  function automatic bit [7:0] model_read(int a);
    case (m_mode)
      0: return m_mem[a];
      1: if (a & 1) return {!m_busy() && !m_psusp, 7'd0};
         else return {!m_busy(), m_esusp, s5, s4, s3, m_psusp, s1, 1'b0};
      2: case (a & 3)
           0: return 8'hA5;
           1: return 8'h3C;
           2: return {7'd0, m_lock[blk_of(a)]};
           default: return 8'h00;
         endcase
      default: case (a & 31)
           16: return 8'h51;
           17: return 8'h52;
           18: return 8'h59;
           19: return 8'h04;
           default: return 8'h00;
         endcase
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step(bus_wr, int'(bus_addr), bus_wdata, vpp_ok);
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      automatic bit [7:0] e = model_read(int'(bus_addr));
      vectors++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s model compare addr=%02h actual=%02h expected=%02h",
                 cur_req, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr=%02h actual=%02h expected=%02h", tag, a, bus_rdata, exp);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired in %s actual=hung expected=done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    rd_chk(8'h00, 8'hFF, "R1");
    rd_chk(8'hC5, 8'hFF, "R1");
    wr(8'h00, 8'h70);
    rd_chk(8'h00, 8'h80, "R1");

    // R4 program with AND semantics, R3 busy layout
    cur_req = "R4";
    wr(8'h00, 8'h40); wr(8'h05, 8'h3C);
    rd_chk(8'h04, 8'h00, "R3");
    idle(PC);
    rd_chk(8'h04, 8'h80, "R4");
    wr(8'h00, 8'hFF);
    rd_chk(8'h05, 8'h3C, "R2");
    wr(8'h00, 8'h40); wr(8'h05, 8'hF0);
    idle(PC + 1);
    wr(8'h00, 8'hFF);
    rd_chk(8'h05, 8'h30, "R4");

    // R6 program suspend / resume
    cur_req = "R6";
    wr(8'h00, 8'h40); wr(8'h06, 8'h00);
    idle(3);
    wr(8'h00, 8'hB0);
    rd_chk(8'h00, 8'h84, "R6");
    wr(8'h00, 8'hFF);
    rd_chk(8'h06, 8'hFF, "R6");
    idle(30);
    rd_chk(8'h06, 8'hFF, "R6");
    wr(8'h00, 8'h70);
    rd_chk(8'h01, 8'h00, "R13");
    wr(8'h00, 8'hD0);
    rd_chk(8'h00, 8'h00, "R6");
    idle(PC + 1);
    rd_chk(8'h00, 8'h80, "R6");
    wr(8'h00, 8'hFF);
    rd_chk(8'h06, 8'h00, "R6");

    // R5 erase and bad confirm, R10 sticky then cleared
    cur_req = "R5";
    wr(8'h00, 8'h20); wr(8'h00, 8'hD0);
    rd_chk(8'h00, 8'h00, "R5");
    idle(EC + 1);
    rd_chk(8'h00, 8'h80, "R5");
    wr(8'h00, 8'hFF);
    rd_chk(8'h05, 8'hFF, "R5");
    rd_chk(8'h06, 8'hFF, "R5");
    wr(8'h40, 8'h20); wr(8'h40, 8'hFF);
    rd_chk(8'h40, 8'hB0, "R5");
    cur_req = "R10";
    wr(8'h40, 8'h70);
    rd_chk(8'h40, 8'hB0, "R10");
    wr(8'h00, 8'h50);
    rd_chk(8'h00, 8'h80, "R10");

    // R7 erase suspend with a program inside
    cur_req = "R7";
    wr(8'h00, 8'h40); wr(8'h45, 8'h11);
    idle(PC + 1);
    wr(8'h40, 8'h20); wr(8'h40, 8'hD0);
    idle(5);
    wr(8'h40, 8'hB0);
    rd_chk(8'h40, 8'hC0, "R7");
    wr(8'h00, 8'h40); wr(8'h80, 8'h0F);
    wr(8'h00, 8'hD0);
    rd_chk(8'h00, 8'h40, "R7");
    idle(PC + 1);
    rd_chk(8'h00, 8'hC0, "R7");
    wr(8'h00, 8'hD0);
    rd_chk(8'h00, 8'h00, "R7");
    idle(EC + 1);
    rd_chk(8'h00, 8'h80, "R7");
    wr(8'h00, 8'hFF);
    rd_chk(8'h45, 8'hFF, "R7");
    rd_chk(8'h80, 8'h0F, "R7");

    // R8 lock bits, R12 identifier
    cur_req = "R8";
    wr(8'h80, 8'h60); wr(8'h80, 8'h01);
    wr(8'h00, 8'h90);
    rd_chk(8'h82, 8'h01, "R8");
    rd_chk(8'h02, 8'h00, "R8");
    rd_chk(8'h00, 8'hA5, "R12");
    rd_chk(8'h01, 8'h3C, "R12");
    rd_chk(8'h03, 8'h00, "R12");
    vpp_ok = 1'b0;
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    vpp_ok = 1'b1;
    rd_chk(8'h00, 8'hA8, "R8");
    wr(8'h00, 8'h90);
    rd_chk(8'h82, 8'h01, "R8");
    wr(8'h00, 8'h50);

    // R9 locked targets, R10 accumulation
    cur_req = "R9";
    wr(8'h00, 8'h40); wr(8'h81, 8'h00);
    rd_chk(8'h00, 8'h92, "R9");
    wr(8'h80, 8'h20); wr(8'h80, 8'hD0);
    rd_chk(8'h00, 8'hB2, "R10");
    wr(8'h00, 8'hFF);
    rd_chk(8'h81, 8'hFF, "R9");
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    wr(8'h00, 8'h90);
    rd_chk(8'h82, 8'h00, "R8");

    // R12 query space
    cur_req = "R12";
    wr(8'h00, 8'h98);
    rd_chk(8'h10, 8'h51, "R12");
    rd_chk(8'h11, 8'h52, "R12");
    rd_chk(8'h12, 8'h59, "R12");
    rd_chk(8'h13, 8'h04, "R12");
    rd_chk(8'h14, 8'h00, "R12");

    // R11 writes ignored while busy, R13 extended status
    cur_req = "R11";
    wr(8'h00, 8'h40); wr(8'h07, 8'h55);
    wr(8'h00, 8'hFF);
    rd_chk(8'h00, 8'h00, "R11");
    wr(8'h00, 8'h90);
    rd_chk(8'h02, 8'h00, "R11");
    rd_chk(8'h03, 8'h00, "R13");
    idle(PC);
    rd_chk(8'h02, 8'h80, "R11");
    rd_chk(8'h03, 8'h80, "R13");
    wr(8'h00, 8'hFF);
    rd_chk(8'h07, 8'h55, "R2");

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule